// File: doc/BRIEF.md
# Termination-Disable Timing Controller

This block models, on the memory side, how a graphics DDR DRAM handles a command that turns off its data-line termination for a short window. A decoded command arrives once per clock: idle (no-operation or deselect), termination-disable, or read. The block then times when the DQ termination switches off and when it comes back on. It also times the read strobe and data-valid windows for a four-word burst.

The block checks the spacing between a termination-disable and a following read. In a two-rank system a read that comes too soon would make both ranks drive the shared read-strobe lines at once, so the block raises a sticky violation flag when that happens. The CAS latency is a registered configuration input. A value outside the supported range raises a configuration-error flag and keeps the termination on.

Top module: `term_disable_ctrl`

## Requirements
- R1: When a termination-disable is registered at edge T with a legal CAS latency CL, `term_en_o` first reads 0 after edge T+CL-1.
- R2: Termination stays off for exactly 4 cycles, from edge T+CL-1 through edge T+CL+2. It reads 1 again after edge T+CL+3.
- R3: A read registered at an edge where 3 or fewer edges have passed since the last termination-disable (that is, fewer than 3 idle cycles in between) sets `spacing_err_o` after that edge. The flag stays set until reset.
- R4: A read issued with at least 3 idle cycles after the last termination-disable, or with no termination-disable since reset, leaves `spacing_err_o` clear.
- R5: A read registered at edge R with a legal CL drives `data_valid_o` high after edges R+CL and R+CL+1 only. These 2 cycles carry four words at double data rate. A new read restarts this timing.
- R6: `strobe_oe_o` equals `data_valid_o`, except that it is 0 in every cycle where `term_en_o` is 0.
- R7: The CAS latency input is registered. Legal values are 5 to 10. `cfg_err_o` shows whether the value registered at the last edge is illegal. While the registered value is illegal, termination is held on, pending windows are cleared, and neither command starts a window. A termination-disable still counts toward the spacing rule of R3.
- R8: A termination-disable that arrives while an earlier window is pending or active restarts the timing of R1 and R2 from the new command.
- R9: A synchronous active-high reset sets `term_en_o` to 1, sets `data_valid_o`, `strobe_oe_o` and `spacing_err_o` to 0, and loads CL = 7.
- R10: Command encoding on `cmd_i`: 2'b00 is a no-operation, 2'b01 is a termination-disable, 2'b10 is a read, and 2'b11 is a deselect. A deselect is treated as idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 2 | Decoded command, encoding as in R10 |
| cas_lat_i | input | 4 | CAS latency in clocks, registered each edge |
| term_en_o | output | 1 | DQ termination enabled (1) or switched off (0) |
| strobe_oe_o | output | 1 | This device drives the read strobe |
| data_valid_o | output | 1 | Read burst data valid window |
| spacing_err_o | output | 1 | Sticky flag for a read issued too soon after a termination-disable |
| cfg_err_o | output | 1 | Registered CAS latency is outside 5 to 10 |

## Verification
Each output comes from a register that is loaded from its own counter. A counter that loads a wrong value, or skips or repeats a step, therefore shows up as a termination or data-valid window that is shifted or resized. The error appears in the first cycle where the window should have opened or closed, at most CL+3 cycles after the command. A wrong gap counter shows up on the first read that falls near a termination-disable, as a flag set or missing in the cycle right after that read. A reference model computes every output in every cycle from edge distances alone, so any such slip is reported in the cycle it occurs.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'b00,
        CMD_TDIS  = 2'b01,
        CMD_READ  = 2'b10,
        CMD_DESEL = 2'b11
    } cmd_e;

    localparam int CL_W_DEF = 4;

endpackage

// File: rtl/tdc_term_window.sv
module tdc_term_window #(
    parameter int CL_W    = 4,
    parameter int CL_MAX  = 10,
    parameter int OFF_LEN = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tdis_i,
    input  logic [CL_W-1:0] cl_i,
    input  logic            cl_ok_i,
    output logic            term_en_o
);
    localparam int WIN_W = $clog2(CL_MAX + OFF_LEN + 1);

    typedef struct packed {
        logic [WIN_W-1:0] cnt;
        logic             term;
    } win_st_t;

    win_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!cl_ok_i) begin
            st_d.cnt = '0;
        end else if (tdis_i) begin
            st_d.cnt = WIN_W'(int'(cl_i) - 1 + OFF_LEN);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        st_d.term = !(cl_ok_i && (st_d.cnt != '0) && (st_d.cnt <= WIN_W'(OFF_LEN)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt  <= '0;
            st_q.term <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign term_en_o = st_q.term;

    // R2: the last count of a window hands termination back on
    a_r2_back_on: assert property (@(posedge clk) disable iff (rst)
        (st_q.cnt == WIN_W'(1) && !tdis_i) |=> term_en_o);

    // R1: one step before the off phase the output must drop
    a_r1_goes_off: assert property (@(posedge clk) disable iff (rst)
        (st_q.cnt == WIN_W'(OFF_LEN + 1) && !tdis_i && cl_ok_i) |=> !term_en_o);

endmodule

// File: rtl/tdc_burst_window.sv
module tdc_burst_window #(
    parameter int CL_W      = 4,
    parameter int CL_MAX    = 10,
    parameter int BURST_CYC = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rd_i,
    input  logic [CL_W-1:0] cl_i,
    input  logic            cl_ok_i,
    output logic            dv_o
);
    localparam int RD_W = $clog2(CL_MAX + BURST_CYC + 1);

    typedef struct packed {
        logic [RD_W-1:0] cnt;
        logic            dv;
    } rd_st_t;

    rd_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!cl_ok_i) begin
            st_d.cnt = '0;
        end else if (rd_i) begin
            st_d.cnt = RD_W'(int'(cl_i) + BURST_CYC);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        st_d.dv = cl_ok_i && (st_d.cnt != '0) && (st_d.cnt <= RD_W'(BURST_CYC));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dv_o = st_q.dv;

    generate
        if (BURST_CYC >= 2) begin : g_len_chk
            // R5: a valid window, once open, lasts past its first cycle
            a_r5_holds: assert property (@(posedge clk) disable iff (rst)
                ($rose(dv_o) && !rd_i && cl_ok_i) |=> dv_o);
        end
    endgenerate

endmodule

// File: rtl/tdc_spacing_chk.sv
module tdc_spacing_chk #(
    parameter int MIN_GAP = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic tdis_i,
    input  logic rd_i,
    output logic err_o
);
    localparam int GAP_W = $clog2(MIN_GAP + 1);

    typedef struct packed {
        logic [GAP_W-1:0] gap;
        logic             err;
    } sp_st_t;

    sp_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_i && (st_q.gap < GAP_W'(MIN_GAP))) begin
            st_d.err = 1'b1;
        end
        if (tdis_i) begin
            st_d.gap = '0;
        end else if (st_q.gap < GAP_W'(MIN_GAP)) begin
            st_d.gap = st_q.gap + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.gap <= GAP_W'(MIN_GAP);
            st_q.err <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign err_o = st_q.err;

    // R3: the flag never clears on its own
    a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);

    // R3: an early read is always reported at the next edge
    a_r3_early_read: assert property (@(posedge clk) disable iff (rst)
        (rd_i && st_q.gap < GAP_W'(MIN_GAP)) |=> err_o);

endmodule

// File: rtl/term_disable_ctrl.sv
module term_disable_ctrl #(
    parameter int CL_W      = tdc_pkg::CL_W_DEF,
    parameter int CL_MIN    = 5,
    parameter int CL_MAX    = 10,
    parameter int CL_RST    = 7,
    parameter int OFF_LEN   = 4,
    parameter int MIN_GAP   = 3,
    parameter int BURST_CYC = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      cmd_i,
    input  logic [CL_W-1:0] cas_lat_i,
    output logic            term_en_o,
    output logic            strobe_oe_o,
    output logic            data_valid_o,
    output logic            spacing_err_o,
    output logic            cfg_err_o
);
    import tdc_pkg::*;

    cmd_e            cmd;
    logic            is_tdis, is_read;
    logic [CL_W-1:0] cl_d, cl_q;
    logic            cl_ok;

    assign cmd     = cmd_e'(cmd_i);
    assign is_tdis = (cmd == CMD_TDIS);
    assign is_read = (cmd == CMD_READ);

    always_comb begin
        cl_d = cas_lat_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cl_q <= CL_W'(CL_RST);
        end else begin
            cl_q <= cl_d;
        end
    end

    assign cl_ok     = (cl_q >= CL_W'(CL_MIN)) && (cl_q <= CL_W'(CL_MAX));
    assign cfg_err_o = !cl_ok;

    tdc_term_window #(
        .CL_W(CL_W), .CL_MAX(CL_MAX), .OFF_LEN(OFF_LEN)
    ) u_term (
        .clk(clk), .rst(rst), .tdis_i(is_tdis), .cl_i(cl_q),
        .cl_ok_i(cl_ok), .term_en_o(term_en_o)
    );

    tdc_burst_window #(
        .CL_W(CL_W), .CL_MAX(CL_MAX), .BURST_CYC(BURST_CYC)
    ) u_burst (
        .clk(clk), .rst(rst), .rd_i(is_read), .cl_i(cl_q),
        .cl_ok_i(cl_ok), .dv_o(data_valid_o)
    );

    tdc_spacing_chk #(
        .MIN_GAP(MIN_GAP)
    ) u_space (
        .clk(clk), .rst(rst), .tdis_i(is_tdis), .rd_i(is_read),
        .err_o(spacing_err_o)
    );

    assign strobe_oe_o = data_valid_o && term_en_o;

    // R7: an illegal latency keeps termination on and data quiet
    a_r7_cfg_term_on: assert property (@(posedge clk) disable iff (rst)
        cfg_err_o |=> term_en_o);

    a_r7_cfg_no_data: assert property (@(posedge clk) disable iff (rst)
        cfg_err_o |=> !data_valid_o);

endmodule

// File: tb/term_disable_ctrl_test.sv
module term_disable_ctrl_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cmd_i = 2'b00;
    logic [3:0] cas_lat_i = 4'd7;
    logic term_en_o, strobe_oe_o, data_valid_o, spacing_err_o, cfg_err_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // model state: edge numbers of last relevant commands
    int n     = 0;
    int t_td  = -1000;
    int t_tdl = -1000;
    int t_rdl = -1000;
    bit m_err = 0;
    int clm   = 7;

    always #5 clk = ~clk;

    term_disable_ctrl uut (
        .clk(clk), .rst(rst), .cmd_i(cmd_i), .cas_lat_i(cas_lat_i),
        .term_en_o(term_en_o), .strobe_oe_o(strobe_oe_o),
        .data_valid_o(data_valid_o), .spacing_err_o(spacing_err_o),
        .cfg_err_o(cfg_err_o)
    );

    function automatic bit legal(int c);
        return (c >= 5) && (c <= 10);
    endfunction

    function automatic bit exp_term(int cl);
        int d = n - t_tdl;
        return !(legal(cl) && d >= cl - 1 && d <= cl + 2);
    endfunction

    function automatic bit exp_dv(int cl);
        int d = n - t_rdl;
        return legal(cl) && d >= cl && d <= cl + 1;
    endfunction

    task automatic chk(string req, string what, bit act, bit exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s at edge %0d: act=%0d exp=%0d", req, what, n, act, exp);
        end
    endtask

    // one clock: drive command, apply edge to model, check after edge
    task automatic cycle(logic [1:0] c);
        int used;
        bit t, dv;
        cmd_i = c;
        @(posedge clk);
        n++;
        used = clm;
        if (c == 2'b10 && (n - t_td) <= 3) m_err = 1;
        if (c == 2'b01) begin
            t_td = n;
            if (legal(used)) t_tdl = n;
        end
        if (c == 2'b10 && legal(used)) t_rdl = n;
        if (!legal(used)) begin
            t_tdl = -1000;
            t_rdl = -1000;
        end
        clm = int'(cas_lat_i);
        t  = exp_term(used);
        dv = exp_dv(used);
        @(negedge clk);
        chk("R1 R2 R8", "term_en", term_en_o, t);
        chk("R5", "data_valid", data_valid_o, dv);
        chk("R6", "strobe_oe", strobe_oe_o, dv && t);
        chk("R3 R4", "spacing_err", spacing_err_o, m_err);
        chk("R7", "cfg_err", cfg_err_o, !legal(clm));
    endtask

    task automatic do_reset();
        cmd_i = 2'b00;
        rst = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        t_td = -1000; t_tdl = -1000; t_rdl = -1000; m_err = 0; clm = 7;
        chk("R9", "term_en in reset", term_en_o, 1'b1);
        chk("R9", "data_valid in reset", data_valid_o, 1'b0);
        chk("R9", "strobe in reset", strobe_oe_o, 1'b0);
        chk("R9", "spacing_err in reset", spacing_err_o, 1'b0);
        chk("R9", "cfg_err in reset", cfg_err_o, 1'b0);
        rst = 1'b0;
    endtask

    task automatic idle(int k);
        for (int i = 0; i < k; i++) cycle(2'b00);
    endtask

    task automatic set_cl(int c);
        cas_lat_i = 4'(c);
        idle(16);
    endtask

    initial begin
        int rv;
        rv = $urandom(32'd4242);
        @(negedge clk);
        do_reset();
        idle(4);

        // R1 R2: single disable at CL=7
        cycle(2'b01); idle(14);
        // R4: read with exactly 3 idle cycles after a disable
        cycle(2'b01); idle(3); cycle(2'b10); idle(14);
        // R6: read just before a disable, strobe suppressed in overlap
        cycle(2'b10); cycle(2'b01); idle(14);
        // R8: second disable restarts a pending window
        cycle(2'b01); idle(2); cycle(2'b01); idle(16);
        // R10: deselect is idle, no flag from 3 deselects
        cycle(2'b01); cycle(2'b11); cycle(2'b11); cycle(2'b11); cycle(2'b10); idle(12);
        // boundary latencies
        set_cl(5);  cycle(2'b01); idle(2); cycle(2'b10); idle(12);
        set_cl(10); cycle(2'b10); idle(1); cycle(2'b01); idle(16);
        // R7: illegal latencies
        set_cl(4);  cycle(2'b01); cycle(2'b10); idle(14);
        set_cl(11); cycle(2'b10); idle(14);
        // R3: flag sticky, then cleared by reset (R9)
        do_reset();
        cycle(2'b01); cycle(2'b10); idle(20);

        for (int seg = 0; seg < 14; seg++) begin
            int c;
            c = 5 + int'($urandom_range(0, 5));
            if (seg % 5 == 4) c = (seg % 2 == 0) ? 3 : 13;
            if (seg == 7) do_reset();
            set_cl(c);
            for (int i = 0; i < 160; i++) begin
                int r;
                r = int'($urandom_range(0, 99));
                if (r < 12)      cycle(2'b01);
                else if (r < 24) cycle(2'b10);
                else if (r < 30) cycle(2'b11);
                else             cycle(2'b00);
            end
            idle(16);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule